// File: doc/BRIEF.md
# Dual-Port Channel Mailbox with Completion and Arrival Interrupts

This block is a shared message store between a host and an I/O coprocessor. Each side has its own byte-wide access port into one address space. That space holds seven outbound (host-to-coprocessor) channels and seven inbound (coprocessor-to-host) channels. Each channel has a 32-byte buffer and a state byte that either side may rewrite. A state holds one of four values: idle, new, received or complete. On an outbound channel the host posts *new*, and the coprocessor steps it through *received* to *complete*. On an inbound channel the two roles are swapped.

The block watches every state write and keeps two sticky flags. The completion flag records that some outbound channel has just entered *complete*. The arrival flag records that some inbound channel has just entered *new*. Each flag is cleared by a write-one-to-clear on the host status register. A single registered host interrupt carries the OR of both flags. A doorbell bit set by the host tells the coprocessor to look at the channel states. The coprocessor clears the doorbell with a pulse.

Address layout, for both access ports:
- bit 9 selects a state byte (1) or a buffer byte (0).
- bit 8 selects the direction: 0 is outbound, 1 is inbound.
- bits 7:5 give the channel number.
- bits 4:0 give the byte offset, and are ignored for state bytes.

Status register bits:
- bit 0 is the doorbell.
- bit 6 is the completion flag.
- bit 7 is the arrival flag.
- All other status bits read 0.

Top module: `mbox_top`

## Requirements
- R1: After reset every state byte reads 0x00 (idle), every buffer byte reads 0x00, and the status register, doorbell and host interrupt are all 0.
- R2: A buffer byte written by either port at an address is returned on both ports' read data one clock after that address is presented on them. A read in the same cycle as a write to the same address returns the old contents. Read data is registered.
- R3: A state write stores only bits 1:0 of the data, using the codes idle=0x00, new=0x01, received=0x02, complete=0x03. The state reads back zero-extended, so writing 0xFF reads back 0x03.
- R4: Status bit 6 sets in the cycle after a write moves any outbound state from another value to complete (0x03). Rewriting complete onto a state that already holds complete does not set it. No inbound state sets it.
- R5: Status bit 7 sets in the cycle after a write moves any inbound state from another value to new (0x01). No outbound state sets it.
- R6: A host status write with bit 6 (or bit 7) at 1 clears that flag, and writing 0 to a flag bit leaves it alone. If a set event and a clear arrive in the same cycle, the flag ends up set.
- R7: The host interrupt is registered, and in every cycle it equals status bit 6 OR status bit 7.
- R8: A host status write with bit 0 at 1 sets the doorbell. A coprocessor acknowledge pulse clears it. When both happen in the same cycle, the doorbell ends up set.
- R9: When both ports write the same buffer or state location in the same cycle, the host's value is stored.
- R10: Writes to channel numbers 7 and above are ignored, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_we | input | 1 | Host write strobe into the channel space |
| h_addr | input | 10 | Host channel-space address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, one clock after the address |
| h_stat_we | input | 1 | Host status register write strobe |
| h_stat_wdata | input | 8 | Host status write data (bit 0 doorbell, bits 6 and 7 clear flags) |
| h_stat_rdata | output | 8 | Status register: bit 7 arrival, bit 6 completion, bit 0 doorbell |
| c_we | input | 1 | Coprocessor write strobe into the channel space |
| c_addr | input | 10 | Coprocessor channel-space address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data, one clock after the address |
| c_bell_ack | input | 1 | Coprocessor doorbell acknowledge pulse |
| bell | output | 1 | Doorbell to the coprocessor |
| host_irq | output | 1 | Registered host interrupt |

## Verification
The bench targets edge detection on the state bytes. Writing complete repeatedly must not re-arm the completion flag after an acknowledge, or the host sees phantom interrupts. Writing new on an outbound channel must not raise the arrival flag, or the host would poll the wrong queue. It also drives an acknowledge in the same cycle as a fresh event, both for a flag and for the doorbell. A design that lets the clear win would drop an event and stall the handshake. Same-cycle writes from both ports to one location and accesses to the unused eighth channel check the write priority and the address guard. A random phase then mixes every kind of access while a reference model is compared on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam logic [1:0] ST_IDLE = 2'd0;
    localparam logic [1:0] ST_NEW  = 2'd1;
    localparam logic [1:0] ST_RCVD = 2'd2;
    localparam logic [1:0] ST_DONE = 2'd3;

    localparam int SB_BELL = 0;
    localparam int SB_SEND = 6;
    localparam int SB_RECV = 7;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int NUM_CH    = 7,
    parameter int MSG_BYTES = 32,
    parameter int DATA_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          h_we,
    input  logic                          h_hit,
    input  logic                          h_dir,
    input  logic [$clog2(NUM_CH)-1:0]     h_ch,
    input  logic [$clog2(MSG_BYTES)-1:0]  h_ofs,
    input  logic [DATA_W-1:0]             h_wdata,
    output logic [DATA_W-1:0]             h_rdata,
    input  logic                          c_we,
    input  logic                          c_hit,
    input  logic                          c_dir,
    input  logic [$clog2(NUM_CH)-1:0]     c_ch,
    input  logic [$clog2(MSG_BYTES)-1:0]  c_ofs,
    input  logic [DATA_W-1:0]             c_wdata,
    output logic [DATA_W-1:0]             c_rdata
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int OFS_W = $clog2(MSG_BYTES);
    localparam int DEPTH = 2 * NUM_CH * MSG_BYTES;
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            h_rd;
        logic [DATA_W-1:0]            c_rd;
    } store_t;

    store_t store_d, store_q;

    function automatic logic [IDX_W-1:0] slot(input logic dir,
                                              input logic [CH_W-1:0] ch,
                                              input logic [OFS_W-1:0] ofs);
        int v;
        v = (int'(dir) * NUM_CH + int'(ch)) * MSG_BYTES + int'(ofs);
        return IDX_W'(v);
    endfunction

    logic [IDX_W-1:0] h_idx, c_idx;
    assign h_idx = slot(h_dir, h_ch, h_ofs);
    assign c_idx = slot(c_dir, c_ch, c_ofs);

    always_comb begin
        store_d = store_q;
        store_d.h_rd = h_hit ? store_q.mem[h_idx] : '0;
        store_d.c_rd = c_hit ? store_q.mem[c_idx] : '0;
        if (c_we) store_d.mem[c_idx] = c_wdata;
        if (h_we) store_d.mem[h_idx] = h_wdata;   // host applied last: host wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    assign h_rdata = store_q.h_rd;
    assign c_rdata = store_q.c_rd;
endmodule

// File: rtl/mbox_state_bank.sv
module mbox_state_bank
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       h_we,
    input  logic                       h_hit,
    input  logic                       h_dir,
    input  logic [$clog2(NUM_CH)-1:0]  h_ch,
    input  logic [1:0]                 h_code,
    output logic [DATA_W-1:0]          h_rdata,
    input  logic                       c_we,
    input  logic                       c_hit,
    input  logic                       c_dir,
    input  logic [$clog2(NUM_CH)-1:0]  c_ch,
    input  logic [1:0]                 c_code,
    output logic [DATA_W-1:0]          c_rdata,
    output logic                       set_send,
    output logic                       set_recv
);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int SLOTS  = 2 * NUM_CH;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOTS-1:0][1:0] st;
        logic [1:0]            h_rd;
        logic [1:0]            c_rd;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [SLOT_W-1:0] sel(input logic dir, input logic [CH_W-1:0] ch);
        int v;
        v = int'(dir) * NUM_CH + int'(ch);
        return SLOT_W'(v);
    endfunction

    logic [SLOT_W-1:0] h_sel, c_sel;
    assign h_sel = sel(h_dir, h_ch);
    assign c_sel = sel(c_dir, c_ch);

    always_comb begin
        bank_d = bank_q;
        bank_d.h_rd = h_hit ? bank_q.st[h_sel] : ST_IDLE;
        bank_d.c_rd = c_hit ? bank_q.st[c_sel] : ST_IDLE;
        if (c_we) bank_d.st[c_sel] = c_code;
        if (h_we) bank_d.st[h_sel] = h_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    logic [NUM_CH-1:0] into_done, into_new;
    for (genvar k = 0; k < NUM_CH; k++) begin : g_edge
        assign into_done[k] = (bank_d.st[k] == ST_DONE) && (bank_q.st[k] != ST_DONE);
        assign into_new[k]  = (bank_d.st[NUM_CH+k] == ST_NEW) && (bank_q.st[NUM_CH+k] != ST_NEW);
    end

    assign set_send = |into_done;
    assign set_recv = |into_new;
    assign h_rdata  = {{(DATA_W-2){1'b0}}, bank_q.h_rd};
    assign c_rdata  = {{(DATA_W-2){1'b0}}, bank_q.c_rd};
endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_send,
    input  logic set_recv,
    input  logic clr_send,
    input  logic clr_recv,
    input  logic ring,
    input  logic bell_ack,
    output logic flag_send,
    output logic flag_recv,
    output logic bell,
    output logic irq
);
    typedef struct packed {
        logic fs;
        logic fr;
        logic bl;
        logic iq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.fs = set_send | (ctl_q.fs & ~clr_send);
        ctl_d.fr = set_recv | (ctl_q.fr & ~clr_recv);
        ctl_d.bl = ring | (ctl_q.bl & ~bell_ack);
        ctl_d.iq = ctl_d.fs | ctl_d.fr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign flag_send = ctl_q.fs;
    assign flag_recv = ctl_q.fr;
    assign bell      = ctl_q.bl;
    assign irq       = ctl_q.iq;
endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int NUM_CH    = 7,
    parameter int MSG_BYTES = 32,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2 + $clog2(NUM_CH) + $clog2(MSG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              h_stat_we,
    input  logic [7:0]        h_stat_wdata,
    output logic [7:0]        h_stat_rdata,
    input  logic              c_we,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    input  logic              c_bell_ack,
    output logic              bell,
    output logic              host_irq
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int OFS_W = $clog2(MSG_BYTES);

    logic            h_is_st, c_is_st, h_dir, c_dir, h_ok, c_ok;
    logic [CH_W-1:0] h_ch, c_ch;
    logic [OFS_W-1:0] h_ofs, c_ofs;

    assign h_is_st = h_addr[ADDR_W-1];
    assign h_dir   = h_addr[ADDR_W-2];
    assign h_ch    = h_addr[OFS_W +: CH_W];
    assign h_ofs   = h_addr[OFS_W-1:0];
    assign h_ok    = int'(h_ch) < NUM_CH;
    assign c_is_st = c_addr[ADDR_W-1];
    assign c_dir   = c_addr[ADDR_W-2];
    assign c_ch    = c_addr[OFS_W +: CH_W];
    assign c_ofs   = c_addr[OFS_W-1:0];
    assign c_ok    = int'(c_ch) < NUM_CH;

    logic [DATA_W-1:0] buf_h_rd, buf_c_rd, st_h_rd, st_c_rd;
    logic set_send, set_recv, flag_send, flag_recv;

    mbox_store #(.NUM_CH(NUM_CH), .MSG_BYTES(MSG_BYTES), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we & ~h_is_st & h_ok), .h_hit(~h_is_st & h_ok),
        .h_dir(h_dir), .h_ch(h_ch), .h_ofs(h_ofs), .h_wdata(h_wdata), .h_rdata(buf_h_rd),
        .c_we(c_we & ~c_is_st & c_ok), .c_hit(~c_is_st & c_ok),
        .c_dir(c_dir), .c_ch(c_ch), .c_ofs(c_ofs), .c_wdata(c_wdata), .c_rdata(buf_c_rd)
    );

    mbox_state_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we & h_is_st & h_ok), .h_hit(h_is_st & h_ok),
        .h_dir(h_dir), .h_ch(h_ch), .h_code(h_wdata[1:0]), .h_rdata(st_h_rd),
        .c_we(c_we & c_is_st & c_ok), .c_hit(c_is_st & c_ok),
        .c_dir(c_dir), .c_ch(c_ch), .c_code(c_wdata[1:0]), .c_rdata(st_c_rd),
        .set_send(set_send), .set_recv(set_recv)
    );

    mbox_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_send(set_send), .set_recv(set_recv),
        .clr_send(h_stat_we & h_stat_wdata[SB_SEND]),
        .clr_recv(h_stat_we & h_stat_wdata[SB_RECV]),
        .ring(h_stat_we & h_stat_wdata[SB_BELL]),
        .bell_ack(c_bell_ack),
        .flag_send(flag_send), .flag_recv(flag_recv),
        .bell(bell), .irq(host_irq)
    );

    logic stat_unused;
    assign stat_unused = ^h_stat_wdata[5:1];

    assign h_rdata      = buf_h_rd | st_h_rd;
    assign c_rdata      = buf_c_rd | st_c_rd;
    assign h_stat_rdata = {flag_recv, flag_send, 5'b0, bell};
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       h_stat_we,
    input logic [7:0] h_stat_wdata,
    input logic [7:0] h_stat_rdata,
    input logic       c_bell_ack,
    input logic       bell,
    input logic       host_irq
);
    // R7
    irq_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == (h_stat_rdata[7] | h_stat_rdata[6]));

    // R6
    send_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_stat_rdata[6]) |-> $past(h_stat_we && h_stat_wdata[6]));

    // R6
    recv_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_stat_rdata[7]) |-> $past(h_stat_we && h_stat_wdata[7]));

    // R8
    bell_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bell) |-> $past(h_stat_we && h_stat_wdata[0]));

    // R8
    bell_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bell) |-> $past(c_bell_ack));
endmodule

bind mbox_top mbox_chk u_chk (
    .clk(clk), .rst_n(rst_n), .h_stat_we(h_stat_we), .h_stat_wdata(h_stat_wdata),
    .h_stat_rdata(h_stat_rdata), .c_bell_ack(c_bell_ack), .bell(bell), .host_irq(host_irq)
);

// File: tb/mbox_top_tb.sv
module mbox_top_tb;
    localparam int CLK_P = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       h_we = 0, c_we = 0, h_stat_we = 0, c_bell_ack = 0;
    logic [9:0] h_addr = 0, c_addr = 0;
    logic [7:0] h_wdata = 0, c_wdata = 0, h_stat_wdata = 0;
    logic [7:0] h_rdata, c_rdata, h_stat_rdata;
    logic       bell, host_irq;

    int checks = 0, fails = 0;
    bit running = 0, done = 0;

    always #(CLK_P/2) clk = ~clk;

    mbox_top u_dut (
        .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_stat_we(h_stat_we), .h_stat_wdata(h_stat_wdata),
        .h_stat_rdata(h_stat_rdata), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_bell_ack(c_bell_ack), .bell(bell), .host_irq(host_irq)
    );

    // reference model
    int m_buf[512];
    int m_st[16];
    bit mf_s, mf_r, m_bell, m_irq;
    int m_hrd, m_crd;

    function automatic int mread(input logic [9:0] a);
        if (a[7:5] >= 3'd7) return 0;
        return a[9] ? m_st[a[8]*8 + a[7:5]] : m_buf[a[8:0]];
    endfunction

    function automatic void mwrite(input logic [9:0] a, input logic [7:0] d);
        if (a[7:5] >= 3'd7) return;
        if (a[9]) m_st[a[8]*8 + a[7:5]] = d & 8'h03;
        else      m_buf[a[8:0]] = d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_buf[i]) m_buf[i] = 0;
            foreach (m_st[i]) m_st[i] = 0;
            mf_s = 0; mf_r = 0; m_bell = 0; m_irq = 0; m_hrd = 0; m_crd = 0;
        end else begin
            int old[16];
            bit s, r;
            m_hrd = mread(h_addr);
            m_crd = mread(c_addr);
            old = m_st;
            if (c_we) mwrite(c_addr, c_wdata);
            if (h_we) mwrite(h_addr, h_wdata);
            s = 0; r = 0;
            for (int k = 0; k < 7; k++) begin
                if (m_st[k] == 3 && old[k] != 3) s = 1;
                if (m_st[8+k] == 1 && old[8+k] != 1) r = 1;
            end
            mf_s = s | (mf_s & !(h_stat_we && h_stat_wdata[6]));
            mf_r = r | (mf_r & !(h_stat_we && h_stat_wdata[7]));
            m_bell = (h_stat_we && h_stat_wdata[0]) | (m_bell & !c_bell_ack);
            m_irq = mf_s | mf_r;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) if (running) begin
        chk("R2 host rdata", h_rdata, m_hrd);
        chk("R2 cop rdata", c_rdata, m_crd);
        chk("R6 status", h_stat_rdata, {mf_r, mf_s, 5'b0, m_bell});
        chk("R7 irq", host_irq, m_irq);
        chk("R8 bell", bell, m_bell);
    end

    function automatic logic [9:0] A(input bit st, input bit dir, input int ch, input int ofs);
        return {st, dir, 3'(ch), 5'(ofs)};
    endfunction

    task automatic drive(input bit hwe, input logic [9:0] ha, input logic [7:0] hd,
                         input bit cwe, input logic [9:0] ca, input logic [7:0] cd,
                         input bit swe, input logic [7:0] sd, input bit ack);
        @(negedge clk);
        h_we = hwe; h_addr = ha; h_wdata = hd;
        c_we = cwe; c_addr = ca; c_wdata = cd;
        h_stat_we = swe; h_stat_wdata = sd; c_bell_ack = ack;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        running = 1;
        idle();
        // R1 reset state
        chk("R1 status", h_stat_rdata, 0);
        chk("R1 irq", host_irq, 0);
        chk("R1 bell", bell, 0);
        drive(0, A(1,0,3,0), 0, 0, A(0,1,6,31), 0, 0, 0, 0);
        idle();
        chk("R1 state read", h_rdata, 0);
        chk("R1 buffer read", c_rdata, 0);

        // R2 buffer write by host, read by coprocessor
        drive(1, A(0,0,2,5), 8'h5A, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, A(0,0,2,5), 0, 0, 0, 0);
        idle();
        chk("R2 cross-port read", c_rdata, 8'h5A);

        // outbound handshake on channel 2, R8 doorbell
        drive(1, A(1,0,2,0), 8'h01, 0, 0, 0, 1, 8'h01, 0);
        idle();
        chk("R8 bell set", bell, 1);
        chk("R4 no flag on new", h_stat_rdata, 8'h01);
        drive(0, 0, 0, 1, A(1,0,2,0), 8'h02, 0, 0, 1);
        idle();
        chk("R8 bell cleared", bell, 0);
        chk("R4 no flag on rcvd", h_stat_rdata, 0);
        drive(0, 0, 0, 1, A(1,0,2,0), 8'h03, 0, 0, 0);
        idle();
        chk("R4 completion flag", h_stat_rdata, 8'h40);
        chk("R7 irq raised", host_irq, 1);
        drive(0, 0, 0, 0, 0, 0, 1, 8'h40, 0);
        idle();
        chk("R6 ack clears", h_stat_rdata, 0);
        chk("R7 irq dropped", host_irq, 0);
        drive(0, 0, 0, 1, A(1,0,2,0), 8'h03, 0, 0, 0);
        idle();
        chk("R4 rewrite no edge", h_stat_rdata, 0);
        drive(0, A(1,0,2,0), 0, 0, 0, 0, 0, 0, 0);
        idle();
        chk("R3 state readback", h_rdata, 8'h03);
        drive(1, A(1,0,2,0), 8'h00, 0, 0, 0, 0, 0, 0);

        // R5 inbound arrival
        drive(0, 0, 0, 1, A(1,1,5,0), 8'h01, 0, 0, 0);
        idle();
        chk("R5 arrival flag", h_stat_rdata, 8'h80);
        // R6 set wins over clear
        drive(0, 0, 0, 1, A(1,1,3,0), 8'h01, 1, 8'h80, 0);
        idle();
        chk("R6 set wins", h_stat_rdata, 8'h80);
        drive(0, 0, 0, 0, 0, 0, 1, 8'h80, 0);
        idle();
        chk("R6 clear arrival", h_stat_rdata, 0);
        drive(1, A(1,0,4,0), 8'h01, 1, A(1,1,1,0), 8'h03, 0, 0, 0);
        idle();
        chk("R5 wrong-direction codes ignored", h_stat_rdata, 0);

        // R3 upper bits dropped
        drive(1, A(1,0,4,0), 8'hFF, 0, 0, 0, 0, 0, 0);
        drive(0, A(1,0,4,0), 0, 0, 0, 0, 0, 0, 0);
        idle();
        chk("R3 masked code", h_rdata, 8'h03);
        chk("R4 flag via masked write", h_stat_rdata, 8'h40);
        drive(0, 0, 0, 0, 0, 0, 1, 8'hC0, 0);

        // R9 same-location collision
        drive(1, A(0,1,1,0), 8'h11, 1, A(0,1,1,0), 8'h22, 0, 0, 0);
        drive(0, A(0,1,1,0), 0, 0, A(0,1,1,0), 0, 0, 0, 0);
        idle();
        chk("R9 host wins host port", h_rdata, 8'h11);
        chk("R9 host wins cop port", c_rdata, 8'h11);

        // R10 channel 7 ignored
        drive(1, A(0,0,7,0), 8'h77, 1, A(1,0,7,0), 8'h03, 0, 0, 0);
        idle();
        chk("R10 no flag from ch7", h_stat_rdata, 0);
        drive(0, A(0,0,7,0), 0, 0, A(1,0,7,0), 0, 0, 0, 0);
        idle();
        chk("R10 buffer read ch7", h_rdata, 0);
        chk("R10 state read ch7", c_rdata, 0);

        // R8 set wins over acknowledge
        drive(0, 0, 0, 0, 0, 0, 1, 8'h01, 1);
        idle();
        chk("R8 set wins", bell, 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle();
        chk("R8 ack clears", bell, 0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [9:0] ha, ca;
            ha = {1'($urandom), 1'($urandom), 3'($urandom), 5'($urandom % 4)};
            ca = {1'($urandom), 1'($urandom), 3'($urandom), 5'($urandom % 4)};
            drive(1'($urandom), ha, 8'($urandom), 1'($urandom), ca, 8'($urandom),
                  ($urandom % 6) == 0, 8'($urandom), ($urandom % 5) == 0);
        end
        idle();
        idle();
        done = 1;
        report();
    end
endmodule